// File: doc/BRIEF.md
# Far Jump and Call Opcode Translator

This block sits in the program-fetch path between external code memory and a core with a 16-bit program counter. When the opcode of an instruction is fetched, it inspects the byte coming from memory. If that byte is one of the short-range jump or call opcodes, the block replaces it with the matching long jump (0x02) or long call (0x12) opcode before the core sees it. It also keeps the three top bits of the original byte. The core then reads two address bytes and loads its own 16-bit counter from them. When the low address byte has been fetched, the block loads the three kept bits into its page register. The page register supplies address bits 18..16, so a single instruction can reach any location in a 512 KB program space.

Far calls and interrupt entry save the current page on a private last-in first-out stack of 3-bit entries. The two return opcodes take the saved value back off that stack. An attempt to save onto a full stack sets a sticky overflow flag and changes no stored entry. An attempt to restore from an empty stack sets a sticky underflow flag and leaves the page unchanged. Each bus cycle is one fetch strobe carrying one memory byte, together with a flag that marks the first cycle of an instruction.

Top module: `far_xlat`

## Requirements
- R1: After synchronous reset the page output is 0, both error flags are low and the stack is empty.
- R2: At a first-cycle fetch, a memory byte whose bits 4..0 are 00001 reaches the core as 0x02. Bits 7..5 of that byte are kept as the pending page.
- R3: At a first-cycle fetch, a memory byte whose bits 4..0 are 10001 reaches the core as 0x12. Bits 7..5 of that byte are kept as the pending page.
- R4: Any byte that is not a first-cycle far opcode reaches the core unchanged. This includes the address bytes and far-opcode patterns that appear in later cycles.
- R5: The page output keeps its old value while the high address byte is fetched. It takes the pending value in the cycle after the low address byte (the second fetch after the opcode) is fetched. For example, the bytes 0xA1, 0x43, 0x21 reach the core as 0x02, 0x43, 0x21 and leave the page at 5.
- R6: A far call pushes the page that was current before the call, at the same edge where it loads the new page. A first-cycle 0x22 pops the stack into the page, and the new page is visible in the next cycle.
- R7: A first-cycle 0x32 restores the page from the stack in the same way as 0x22.
- R8: A pulse on irq_vec pushes the current page and leaves the page unchanged.
- R9: The stack is last-in first-out and holds 64 entries, so nested calls and interrupts unwind in reverse order.
- R10: A push while 64 entries are stored sets ovf_err, which stays set until reset. The stored entries do not change, and the far call still loads its new page.
- R11: A return on an empty stack sets unf_err, which stays set until reset. The page does not change.
- R12: The page changes only in the cycle after a fetch strobe that ends a far instruction or is a return opcode fetch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_vld | input | 1 | One program byte is fetched in this cycle |
| fetch_first | input | 1 | This fetch is the first bus cycle of an instruction |
| irq_vec | input | 1 | Single-cycle pulse at interrupt vectoring |
| mem_data | input | 8 | Byte read from code memory |
| core_data | output | 8 | Byte forwarded to the core (combinational) |
| page_ext | output | 3 | Extended address bits 18..16 |
| ovf_err | output | 1 | Sticky flag for a push onto a full stack |
| unf_err | output | 1 | Sticky flag for a pop from an empty stack |

## Verification
The assertions assume a well-formed instruction stream. Every far opcode is followed by exactly two non-first fetches before the next first-cycle fetch, and no irq_vec pulse falls in a cycle that also carries a fetch strobe. The stimulus builds every instruction with the same tasks, so it always issues complete three-byte far sequences. It drives interrupt pulses only in idle cycles and places return opcodes only at instruction starts. It still covers far patterns in address-byte positions, fetch-idle cycles, deep nesting and both stack limits.

// File: rtl/far_xlat_pkg.sv
package far_xlat_pkg;
    localparam int BYTE_W  = 8;
    localparam int PAGE_W  = 3;
    localparam int LOW_W   = 5;

    localparam logic [LOW_W-1:0]  LOW_FJMP  = 5'b00001;
    localparam logic [LOW_W-1:0]  LOW_FCALL = 5'b10001;
    localparam logic [BYTE_W-1:0] OPC_LJMP  = 8'h02;
    localparam logic [BYTE_W-1:0] OPC_LCALL = 8'h12;
    localparam logic [BYTE_W-1:0] OPC_RET   = 8'h22;
    localparam logic [BYTE_W-1:0] OPC_RETI  = 8'h32;

    typedef enum logic [1:0] {
        K_PLAIN = 2'd0,
        K_FJMP  = 2'd1,
        K_FCALL = 2'd2,
        K_RET   = 2'd3
    } op_kind_e;

    typedef struct packed {
        op_kind_e              kind;
        logic [PAGE_W-1:0]     page;
    } op_info_t;

    function automatic op_info_t classify(input logic [BYTE_W-1:0] b);
        op_info_t r;
        r.page = b[BYTE_W-1 -: PAGE_W];
        if (b[LOW_W-1:0] == LOW_FJMP)
            r.kind = K_FJMP;
        else if (b[LOW_W-1:0] == LOW_FCALL)
            r.kind = K_FCALL;
        else if (b == OPC_RET || b == OPC_RETI)
            r.kind = K_RET;
        else
            r.kind = K_PLAIN;
        return r;
    endfunction
endpackage

// File: rtl/far_xlat_decode.sv
module far_xlat_decode
    import far_xlat_pkg::*;
(
    input  logic              fetch_vld,
    input  logic              fetch_first,
    input  logic [BYTE_W-1:0] mem_data,
    output op_info_t          info,
    output logic [BYTE_W-1:0] core_data
);
    logic opc_cycle;

    assign opc_cycle = fetch_vld & fetch_first;

    always_comb begin
        info = classify(mem_data);
        if (!opc_cycle)
            info.kind = K_PLAIN;
    end

    always_comb begin
        unique case (info.kind)
            K_FJMP:  core_data = OPC_LJMP;
            K_FCALL: core_data = OPC_LCALL;
            default: core_data = mem_data;
        endcase
    end
endmodule

// File: rtl/far_xlat_seq.sv
module far_xlat_seq
    import far_xlat_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_vld,
    input  logic              fetch_first,
    input  op_info_t          info,
    output logic              done,
    output logic              done_call,
    output logic [PAGE_W-1:0] hold
);
    localparam logic [1:0] ADDR_BYTES = 2'd2;

    logic [1:0] pend_cnt;
    logic       pend_call;

    assign done      = fetch_vld & ~fetch_first & (pend_cnt == 2'd1);
    assign done_call = done & pend_call;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cnt  <= '0;
            pend_call <= 1'b0;
            hold      <= '0;
        end else if (fetch_vld && fetch_first) begin
            if (info.kind == K_FJMP || info.kind == K_FCALL) begin
                pend_cnt  <= ADDR_BYTES;
                pend_call <= (info.kind == K_FCALL);
                hold      <= info.page;
            end else begin
                pend_cnt  <= '0;
                pend_call <= 1'b0;
            end
        end else if (fetch_vld && pend_cnt != 2'd0) begin
            pend_cnt <= pend_cnt - 2'd1;
        end
    end
endmodule

// File: rtl/far_xlat_stack.sv
module far_xlat_stack #(
    parameter int DEPTH = 64,
    parameter int W     = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         full,
    output logic         empty
);
    localparam int CW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [CW:0]   cnt;
    logic [CW-1:0] top_idx;
    logic [CW-1:0] wr_idx;

    assign top_idx = CW'(cnt - 1'b1);
    assign wr_idx  = cnt[CW-1:0];
    assign full    = (cnt == (CW+1)'(DEPTH));
    assign empty   = (cnt == '0);
    assign top     = mem[top_idx];

    always_ff @(posedge clk) begin
        if (push && !full)
            mem[wr_idx] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (push && !full)
            cnt <= cnt + 1'b1;
        else if (pop && !empty)
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/far_xlat.sv
module far_xlat
    import far_xlat_pkg::*;
#(
    parameter int STACK_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fetch_vld,
    input  logic              fetch_first,
    input  logic              irq_vec,
    input  logic [BYTE_W-1:0] mem_data,
    output logic [BYTE_W-1:0] core_data,
    output logic [PAGE_W-1:0] page_ext,
    output logic              ovf_err,
    output logic              unf_err
);
    op_info_t          info;
    logic              done, done_call;
    logic [PAGE_W-1:0] hold;
    logic              push, pop;
    logic [PAGE_W-1:0] stk_top;
    logic              stk_full, stk_empty;

    far_xlat_decode u_dec (
        .fetch_vld   (fetch_vld),
        .fetch_first (fetch_first),
        .mem_data    (mem_data),
        .info        (info),
        .core_data   (core_data)
    );

    far_xlat_seq u_seq (
        .clk         (clk),
        .rst         (rst),
        .fetch_vld   (fetch_vld),
        .fetch_first (fetch_first),
        .info        (info),
        .done        (done),
        .done_call   (done_call),
        .hold        (hold)
    );

    assign push = done_call | irq_vec;
    assign pop  = (info.kind == K_RET);

    far_xlat_stack #(.DEPTH(STACK_DEPTH), .W(PAGE_W)) u_stk (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .pop   (pop),
        .din   (page_ext),
        .top   (stk_top),
        .full  (stk_full),
        .empty (stk_empty)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            page_ext <= '0;
            ovf_err  <= 1'b0;
            unf_err  <= 1'b0;
        end else begin
            if (done)
                page_ext <= hold;
            else if (pop && !stk_empty)
                page_ext <= stk_top;
            if (push && stk_full)
                ovf_err <= 1'b1;
            if (pop && stk_empty)
                unf_err <= 1'b1;
        end
    end
endmodule

// File: rtl/far_xlat_chk.sv
module far_xlat_chk (
    input logic       clk,
    input logic       rst,
    input logic       fetch_vld,
    input logic       fetch_first,
    input logic       irq_vec,
    input logic [7:0] mem_data,
    input logic [7:0] core_data,
    input logic [2:0] page_ext,
    input logic       ovf_err,
    input logic       unf_err
);
    assert_jmp_subst_R2: assert property (@(posedge clk) disable iff (rst)
        (fetch_vld && fetch_first && mem_data[4:0] == 5'b00001) |-> core_data == 8'h02);

    assert_call_subst_R3: assert property (@(posedge clk) disable iff (rst)
        (fetch_vld && fetch_first && mem_data[4:0] == 5'b10001) |-> core_data == 8'h12);

    assert_pass_through_R4: assert property (@(posedge clk) disable iff (rst)
        (fetch_vld && !fetch_first) |-> core_data == mem_data);

    assert_page_quiet_R12: assert property (@(posedge clk) disable iff (rst)
        !$past(fetch_vld) |-> $stable(page_ext));

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        $past(ovf_err) |-> ovf_err);

    assert_unf_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        $past(unf_err) |-> unf_err);

    assert_unf_cause_R11: assert property (@(posedge clk) disable iff (rst)
        $rose(unf_err) |-> $past(fetch_vld && fetch_first &&
                                 (mem_data == 8'h22 || mem_data == 8'h32)));

    assert_ovf_cause_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_err) |-> $past(irq_vec || (fetch_vld && !fetch_first)));
endmodule

bind far_xlat far_xlat_chk u_chk (.*);

// File: tb/test_far_xlat.sv
`timescale 1ns/1ps
module test_far_xlat;
    logic       clk = 1'b0;
    logic       rst;
    logic       fetch_vld, fetch_first, irq_vec;
    logic [7:0] mem_data;
    logic [7:0] core_data;
    logic [2:0] page_ext;
    logic       ovf_err, unf_err;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    int ref_page, ref_pend, ref_hold;
    bit ref_call, ref_ovf, ref_unf;
    int ref_stack[$];

    always #4 clk = ~clk;

    far_xlat i_far_xlat (
        .clk(clk), .rst(rst), .fetch_vld(fetch_vld), .fetch_first(fetch_first),
        .irq_vec(irq_vec), .mem_data(mem_data), .core_data(core_data),
        .page_ext(page_ext), .ovf_err(ovf_err), .unf_err(unf_err)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic ref_push();
        if (ref_stack.size() == 64) ref_ovf = 1;
        else ref_stack.push_back(ref_page);
    endtask

    task automatic step(input bit v, input bit f, input int d, input bit irq, input string tag);
        int exp_core;
        @(negedge clk);
        cmp(tag, "page_ext", int'(page_ext), ref_page);
        cmp(tag, "ovf_err", int'(ovf_err), int'(ref_ovf));
        cmp(tag, "unf_err", int'(unf_err), int'(ref_unf));
        fetch_vld = v; fetch_first = f; mem_data = 8'(d); irq_vec = irq;
        #1;
        exp_core = d;
        if (v && f && (d % 32) == 1)  exp_core = 'h02;
        if (v && f && (d % 32) == 17) exp_core = 'h12;
        cmp(tag, "core_data", int'(core_data), exp_core);
        if (v && f) begin
            if ((d % 32) == 1 || (d % 32) == 17) begin
                ref_pend = 2; ref_call = ((d % 32) == 17); ref_hold = d / 32;
            end else begin
                ref_pend = 0;
                if (d == 'h22 || d == 'h32) begin
                    if (ref_stack.size() == 0) ref_unf = 1;
                    else ref_page = ref_stack.pop_back();
                end
            end
        end else if (v && ref_pend > 0) begin
            ref_pend--;
            if (ref_pend == 0) begin
                if (ref_call) ref_push();
                ref_page = ref_hold;
            end
        end
        if (irq) ref_push();
    endtask

    task automatic far_op(input int opc, input int hi, input int lo, input string tag);
        step(1, 1, opc, 0, tag);
        step(1, 0, hi, 0, tag);
        step(1, 0, lo, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst = 1; fetch_vld = 0; fetch_first = 0; irq_vec = 0; mem_data = 0;
        ref_page = 0; ref_pend = 0; ref_hold = 0; ref_call = 0; ref_ovf = 0; ref_unf = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        // R1: reset state, checked on an idle cycle
        step(0, 0, 'h00, 0, "R1");
        // R2 R5: worked example bytes A1 43 21 lead to page 5
        far_op('hA1, 'h43, 'h21, "R5");
        step(0, 0, 'h00, 0, "R5");
        // R4: plain opcodes and far patterns in address-byte cycles pass through
        step(1, 1, 'h74, 0, "R4");
        step(1, 0, 'hA1, 0, "R4");
        step(1, 0, 'h71, 0, "R4");
        step(0, 1, 'hE1, 0, "R4");
        // R2: every far jump page value
        for (int p = 0; p < 8; p++) far_op(p * 32 + 1, 'h12, 'h34, "R2");
        // R3 R6: far call pushes old page, RET restores
        far_op('h71, 'h12, 'h34, "R3");
        step(1, 1, 'h22, 0, "R6");
        step(1, 1, 'h00, 0, "R6");
        // R8 R7 R9: nesting with an interrupt, unwind in reverse
        far_op('h51, 'h00, 'h10, "R9");
        step(0, 0, 'h00, 1, "R8");
        far_op('h11, 'h00, 'h20, "R9");
        step(0, 0, 'h00, 1, "R8");
        step(1, 1, 'h32, 0, "R7");
        step(1, 1, 'h22, 0, "R9");
        step(1, 1, 'h32, 0, "R7");
        step(1, 1, 'h22, 0, "R9");
        step(0, 0, 'h00, 0, "R9");
        // R11: return on empty stack
        step(1, 1, 'h22, 0, "R11");
        step(0, 0, 'h00, 0, "R11");
        step(1, 1, 'h04, 0, "R11");
        // R10: fill 64 entries, then one more push
        for (int i = 0; i < 64; i++) far_op(((i % 8) * 32) + 17, 'h00, 'h00, "R10");
        far_op('hF1, 'h00, 'h00, "R10");
        step(0, 0, 'h00, 0, "R10");
        step(1, 1, 'h22, 0, "R10");
        step(1, 1, 'h22, 0, "R10");
        step(0, 0, 'h00, 0, "R12");
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule